// File: doc/BRIEF.md
# Differential Clock Stop and Power-Down Gate

This block sits after a clock synthesizer and gates a group of differential clock output pairs. Each pair is either stoppable or non-stop. Two active-low control inputs, a stop request and a power-down request, arrive without any relation to the source clock. They pass through a synchronizer and then move the block between three modes: running, stopped and powered down. Two configuration bits decide whether parked pairs are held at a driven level or left floating.

Every pair has a true and a complement output and a two-bit state code. The state code stands in for the analog drive level that a pad would present. Mode changes take effect only at the source-clock edge where the internal reference phase falls from high to low. Because of this, no output ever shows a shortened or lengthened pulse while it is running, and every park and resume begins on a clean boundary. Pairs `0 .. NUM_STOPPABLE-1` are stoppable and the remaining pairs are non-stop.

Top module: `clkStopGate`

## Requirements
- R1: While `rstN` is low, every pair reports state code 0 (running), every `clkTrue` bit is 0 and every `clkComp` bit is 1.
- R2: With `pwrDnN`=1 and `stopReqN`=1, every pair reports code 0 for all four settings of the configuration bits, and `clkComp` is the inverse of `clkTrue` for each pair.
- R3: In stop mode (`stopReqN`=0, `pwrDnN`=1), non-stop pairs keep reporting code 0 and keep toggling, whatever the configuration bits are.
- R4: In stop mode with `cfgStopFloat`=0, stoppable pairs report code 1 (driven park), with true held at 1 and complement at 0.
- R5: In stop mode with `cfgStopFloat`=1, stoppable pairs report code 3 (high-Z), with both outputs at 0.
- R6: In power-down mode (`pwrDnN`=0) with both configuration bits 0, every pair reports code 2 (true at the low drive level, complement driven low), with both outputs at 0.
- R7: In power-down mode with either configuration bit set, every pair reports code 3, with both outputs at 0.
- R8: Power-down overrides stop: with `pwrDnN`=0, the level of `stopReqN` has no effect on any code or output.
- R9: A pair's state code leaves 0 only at an edge where its true output was 1 just before, and returns to 0 only with its true output at 0. Each high or low interval of a true output that begins and ends while the pair is running lasts exactly `HALF_CYCLES` source cycles.
- R10: After either control input changes, the new mode's codes appear on all affected pairs within `SYNC_STAGES + 4*HALF_CYCLES` source cycles. This covers stopped pairs resuming after the stop request is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReqN | input | 1 | Asynchronous active-low stop request |
| pwrDnN | input | 1 | Asynchronous active-low power-down request |
| cfgStopFloat | input | 1 | Parked stoppable pairs float in stop mode; also forces float in power-down |
| cfgDownFloat | input | 1 | Forces float in power-down mode |
| clkTrue | output | NUM_STOPPABLE+NUM_FREE | True output of each pair |
| clkComp | output | NUM_STOPPABLE+NUM_FREE | Complement output of each pair |
| pairState | output | 2*(NUM_STOPPABLE+NUM_FREE) | Per-pair code: 0 run, 1 driven stop park, 2 driven power-down park, 3 high-Z |

## Verification
The hardest situation to reach from the ports is a control input changing at an arbitrary point within the output period. This matters most just before or after the falling boundary, where a runt or stretched pulse could form when a park begins or ends. The bench holds random combinations of stop, power-down and configuration for a settle window, while a monitor measures every pulse of every true output. Over many cycles the monitor sees entries and exits at every phase offset. Resume latency is measured directly by counting cycles from the release of the stop request until all stoppable pairs report running.

// File: rtl/clkGatePkg.sv
package clkGatePkg;

  typedef enum logic [1:0] {
    PAIR_RUN        = 2'd0,
    PAIR_STOP_DRIVE = 2'd1,
    PAIR_DOWN_DRIVE = 2'd2,
    PAIR_FLOAT      = 2'd3
  } pairState_e;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_STOP = 2'd1,
    MODE_DOWN = 2'd2
  } gateMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic      flip;  // reference phase toggles at this edge
    gateMode_e mode;  // mode currently applied to the outputs
  } gateStrobe_t;

endpackage

// File: rtl/gateCtrl.sv
module gateCtrl
  import clkGatePkg::*;
#(
  parameter int HALF_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stopReqN,
  input  logic        pwrDnN,
  input  logic        phaseHigh,
  output gateStrobe_t strobe
);

  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [SYNC_STAGES-1:0] stopChain;
  logic [SYNC_STAGES-1:0] downChain;
  logic                   stopReq;
  logic                   downReq;
  logic [CW-1:0]          halfCnt;
  logic                   flip;
  logic                   boundary;
  gateMode_e              mode;
  gateMode_e              modeNext;

  // two-flop style synchronizers, stored active-high
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stopChain <= '0;
          downChain <= '0;
        end else begin
          stopChain <= ~stopReqN;
          downChain <= ~pwrDnN;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stopChain <= '0;
          downChain <= '0;
        end else begin
          stopChain <= {stopChain[SYNC_STAGES-2:0], ~stopReqN};
          downChain <= {downChain[SYNC_STAGES-2:0], ~pwrDnN};
        end
      end
    end
  endgenerate

  assign stopReq = stopChain[SYNC_STAGES-1];
  assign downReq = downChain[SYNC_STAGES-1];

  // half-period timer of the reference phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        halfCnt <= '0;
    else if (flip)    halfCnt <= '0;
    else              halfCnt <= halfCnt + 1'b1;
  end

  assign flip     = (halfCnt == LAST);
  assign boundary = flip && phaseHigh;

  always_comb begin
    if (downReq)      modeNext = MODE_DOWN;
    else if (stopReq) modeNext = MODE_STOP;
    else              modeNext = MODE_RUN;
  end

  // mode only moves where the reference falls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         mode <= MODE_RUN;
    else if (boundary) mode <= modeNext;
  end

  assign strobe.flip = flip;
  assign strobe.mode = mode;

  AST_MODE_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (mode != $past(mode)) |-> $past(flip && phaseHigh))
    else $error("mode moved off the falling boundary"); // R9

  AST_DOWN_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && downReq) |=> (mode == MODE_DOWN))
    else $error("power-down did not override"); // R8

  AST_IDLE_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && !downReq && !stopReq) |=> (mode == MODE_RUN))
    else $error("idle controls did not give run mode"); // R2

endmodule

// File: rtl/gatePath.sv
module gatePath
  import clkGatePkg::*;
#(
  parameter int NUM_STOPPABLE = 2,
  parameter int NUM_FREE      = 2
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  gateStrobe_t                               strobe,
  input  logic                                      cfgStopFloat,
  input  logic                                      cfgDownFloat,
  output logic                                      phaseHigh,
  output logic [NUM_STOPPABLE+NUM_FREE-1:0]         clkTrue,
  output logic [NUM_STOPPABLE+NUM_FREE-1:0]         clkComp,
  output logic [2*(NUM_STOPPABLE+NUM_FREE)-1:0]     pairState
);

  localparam int NUM_PAIRS = NUM_STOPPABLE + NUM_FREE;

  logic phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            phase <= 1'b0;
    else if (strobe.flip) phase <= ~phase;
  end

  assign phaseHigh = phase;

  generate
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      pairState_e code;

      if (p < NUM_STOPPABLE) begin : g_stoppable
        always_comb begin
          unique case (strobe.mode)
            MODE_STOP: code = cfgStopFloat ? PAIR_FLOAT : PAIR_STOP_DRIVE;
            MODE_DOWN: code = (cfgStopFloat || cfgDownFloat) ? PAIR_FLOAT
                                                             : PAIR_DOWN_DRIVE;
            default:   code = PAIR_RUN;
          endcase
        end
      end else begin : g_free
        always_comb begin
          if (strobe.mode == MODE_DOWN)
            code = (cfgStopFloat || cfgDownFloat) ? PAIR_FLOAT : PAIR_DOWN_DRIVE;
          else
            code = PAIR_RUN;
        end

        AST_FREE_RUNS: assert property (@(posedge clk) disable iff (!rstN)
          (strobe.mode == MODE_STOP) |-> (pairState[2*p +: 2] == 2'd0))
          else $error("non-stop pair parked in stop mode"); // R3
      end

      always_comb begin
        unique case (code)
          PAIR_RUN:        begin clkTrue[p] = phase; clkComp[p] = ~phase; end
          PAIR_STOP_DRIVE: begin clkTrue[p] = 1'b1;  clkComp[p] = 1'b0;   end
          default:         begin clkTrue[p] = 1'b0;  clkComp[p] = 1'b0;   end
        endcase
      end

      assign pairState[2*p +: 2] = code;

      AST_COMP_INVERTS: assert property (@(posedge clk) disable iff (!rstN)
        (pairState[2*p +: 2] == 2'd0) |-> (clkComp[p] == !clkTrue[p]))
        else $error("complement not inverse while running"); // R2

      AST_DOWN_POLICY: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.mode == MODE_DOWN && !cfgStopFloat && !cfgDownFloat)
          |-> (pairState[2*p +: 2] == 2'd2 && !clkTrue[p] && !clkComp[p]))
        else $error("power-down driven park wrong"); // R6
    end
  endgenerate

  AST_PHASE_ON_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (phase != $past(phase)) |-> $past(strobe.flip))
    else $error("reference phase moved without flip"); // R9

endmodule

// File: rtl/clkStopGate.sv
module clkStopGate
  import clkGatePkg::*;
#(
  parameter int NUM_STOPPABLE = 2,
  parameter int NUM_FREE      = 2,
  parameter int HALF_CYCLES   = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  stopReqN,
  input  logic                                  pwrDnN,
  input  logic                                  cfgStopFloat,
  input  logic                                  cfgDownFloat,
  output logic [NUM_STOPPABLE+NUM_FREE-1:0]     clkTrue,
  output logic [NUM_STOPPABLE+NUM_FREE-1:0]     clkComp,
  output logic [2*(NUM_STOPPABLE+NUM_FREE)-1:0] pairState
);

  gateStrobe_t strobe;
  logic        phaseHigh;

  gateCtrl #(
    .HALF_CYCLES (HALF_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stopReqN  (stopReqN),
    .pwrDnN    (pwrDnN),
    .phaseHigh (phaseHigh),
    .strobe    (strobe)
  );

  gatePath #(
    .NUM_STOPPABLE (NUM_STOPPABLE),
    .NUM_FREE      (NUM_FREE)
  ) path (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgStopFloat (cfgStopFloat),
    .cfgDownFloat (cfgDownFloat),
    .phaseHigh    (phaseHigh),
    .clkTrue      (clkTrue),
    .clkComp      (clkComp),
    .pairState    (pairState)
  );

endmodule

// File: tb/clkStopGate_test.sv
module clkStopGate_test;

  localparam int NS   = 2;
  localparam int NF   = 2;
  localparam int NP   = NS + NF;
  localparam int HALF = 2;
  localparam int SYNC = 2;
  localparam int BOUND = SYNC + 4*HALF;
  localparam int HOLD  = BOUND + 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReqN = 1'b1;
  logic pwrDnN = 1'b1;
  logic cfgStopFloat = 1'b0;
  logic cfgDownFloat = 1'b0;
  logic [NP-1:0]   clkTrue;
  logic [NP-1:0]   clkComp;
  logic [2*NP-1:0] pairState;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  clkStopGate #(.NUM_STOPPABLE(NS), .NUM_FREE(NF),
                .HALF_CYCLES(HALF), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rstN(rstN), .stopReqN(stopReqN), .pwrDnN(pwrDnN),
    .cfgStopFloat(cfgStopFloat), .cfgDownFloat(cfgDownFloat),
    .clkTrue(clkTrue), .clkComp(clkComp), .pairState(pairState)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] expCode(input int p, input logic sN, input logic dN,
                                         input logic cs, input logic cd);
    if (!dN) return (cs || cd) ? 2'd3 : 2'd2;
    if (!sN && p < NS) return cs ? 2'd3 : 2'd1;
    return 2'd0;
  endfunction

  // compare every pair with the policy for the present inputs
  task automatic checkPolicy(input string req);
    for (int p = 0; p < NP; p++) begin
      logic [1:0] e;
      e = expCode(p, stopReqN, pwrDnN, cfgStopFloat, cfgDownFloat);
      check(pairState[2*p +: 2] == e, req, $sformatf("code pair %0d", p),
            pairState[2*p +: 2], e);
      case (e)
        2'd0: check(clkComp[p] == !clkTrue[p], req, $sformatf("comp inverse pair %0d", p),
                    clkComp[p], !clkTrue[p]);
        2'd1: check({clkTrue[p], clkComp[p]} == 2'b10, req, $sformatf("stop levels pair %0d", p),
                    {clkTrue[p], clkComp[p]}, 2);
        default: check({clkTrue[p], clkComp[p]} == 2'b00, req, $sformatf("park levels pair %0d", p),
                       {clkTrue[p], clkComp[p]}, 0);
      endcase
    end
  endtask

  task automatic settle();
    repeat (HOLD) @(negedge clk);
  endtask

  // pulse and boundary monitor (R9)
  logic       prevT [NP];
  logic [1:0] prevC [NP];
  int         width [NP];
  bit         whole [NP];

  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (!rstN) begin
        prevT[p] = clkTrue[p];
        prevC[p] = pairState[2*p +: 2];
        width[p] = 0;
        whole[p] = 1'b0;
      end else begin
        logic [1:0] c;
        c = pairState[2*p +: 2];
        if (prevC[p] == 2'd0 && c != 2'd0)
          check(prevT[p] == 1'b1, "R9", $sformatf("park entry level pair %0d", p), prevT[p], 1);
        if (prevC[p] != 2'd0 && c == 2'd0)
          check(clkTrue[p] == 1'b0, "R9", $sformatf("resume level pair %0d", p), clkTrue[p], 0);
        if (clkTrue[p] != prevT[p]) begin
          if (whole[p])
            check(width[p] == HALF, "R9", $sformatf("pulse width pair %0d", p), width[p], HALF);
          width[p] = 1;
          whole[p] = (c == 2'd0);
        end else begin
          width[p]++;
          if (c != 2'd0) whole[p] = 1'b0;
        end
        prevT[p] = clkTrue[p];
        prevC[p] = c;
      end
    end
  end

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      check(pairState[2*p +: 2] == 2'd0, "R1", $sformatf("reset code pair %0d", p),
            pairState[2*p +: 2], 0);
      check(clkTrue[p] == 1'b0 && clkComp[p] == 1'b1, "R1", $sformatf("reset levels pair %0d", p),
            {clkTrue[p], clkComp[p]}, 1);
    end
    rstN = 1'b1;
    settle();
  endtask

  task automatic testRunAllCfg();
    stopReqN = 1'b1; pwrDnN = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cfgStopFloat = k[0]; cfgDownFloat = k[1];
      settle();
      checkPolicy("R2");
    end
  endtask

  task automatic testStop();
    for (int k = 0; k < 4; k++) begin
      cfgStopFloat = k[0]; cfgDownFloat = k[1];
      stopReqN = 1'b0;
      settle();
      checkPolicy(k[0] ? "R5" : "R4");
      for (int p = NS; p < NP; p++)
        check(pairState[2*p +: 2] == 2'd0, "R3", $sformatf("free pair %0d running", p),
              pairState[2*p +: 2], 0);
      begin
        int n = 0;
        bit allRun = 1'b0;
        @(negedge clk);
        stopReqN = 1'b1;
        while (!allRun && n < 4*BOUND) begin
          @(negedge clk);
          n++;
          allRun = 1'b1;
          for (int p = 0; p < NS; p++)
            if (pairState[2*p +: 2] != 2'd0) allRun = 1'b0;
        end
        check(allRun && n <= BOUND, "R10", "resume latency", n, BOUND);
      end
      settle();
    end
  endtask

  task automatic testDown();
    for (int k = 0; k < 4; k++) begin
      logic [2*NP-1:0] withStop;
      cfgStopFloat = k[0]; cfgDownFloat = k[1];
      stopReqN = 1'b1;
      begin
        int n = 0;
        bit allPark = 1'b0;
        @(negedge clk);
        pwrDnN = 1'b0;
        while (!allPark && n < 4*BOUND) begin
          @(negedge clk);
          n++;
          allPark = 1'b1;
          for (int p = 0; p < NP; p++)
            if (pairState[2*p +: 2] == 2'd0) allPark = 1'b0;
        end
        check(allPark && n <= BOUND, "R10", "power-down latency", n, BOUND);
      end
      settle();
      checkPolicy(k == 0 ? "R6" : "R7");
      withStop = pairState;
      stopReqN = 1'b0;
      settle();
      check(pairState == withStop, "R8", "stop ignored in power-down", pairState, withStop);
      checkPolicy("R8");
      pwrDnN = 1'b1; stopReqN = 1'b1;
      settle();
    end
  endtask

  task automatic testRandom();
    for (int r = 0; r < 300; r++) begin
      int unsigned v;
      v = $urandom;
      stopReqN = v[0]; pwrDnN = v[1] | v[4]; cfgStopFloat = v[2]; cfgDownFloat = v[3];
      repeat (v[9:6]) @(negedge clk);
      settle();
      checkPolicy("R9");
    end
    stopReqN = 1'b1; pwrDnN = 1'b1; cfgStopFloat = 1'b0; cfgDownFloat = 1'b0;
    settle();
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testRunAllCfg();
    testStop();
    testDown();
    testRandom();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule